// File: doc/BRIEF.md
# Per-Range Credit Rate Limiter

This block sits on one address channel (write or read) of an AXI4-Lite link, between a master and the rest of the interconnect. It limits how often the master may use selected address ranges. Each range is described by a base/mask pair and owns a credit counter. A request whose address falls into a range may pass only while that range's counter holds credit. Each completed handshake toward the slave spends one credit.

Every counter is restored to a fixed maximum at a fixed period. When a range runs out of credit, its requests are stalled rather than refused. The block holds VALID low toward the slave and READY low toward the master until the next refill. Addresses outside every range pass untouched. The path from master to slave is purely combinational, so the block adds no cycles of latency.

Top module: `credit_gate`

## Requirements
- R1: Reset (rst_n low) sets every rule's counter to CREDITS and the refill timer to zero. Right after reset is released, CREDITS back-to-back handshakes to one rule complete without a stall.
- R2: An address a matches rule i when (a XOR base_i) AND mask_i is zero. Rule i occupies bits [i*ADDR_W +: ADDR_W] of RULE_BASE and of RULE_MASK. An address that matches no rule always passes: dn_valid equals up_valid and up_ready equals dn_ready.
- R3: While the charged rule has credit, or no rule matches, the same cycle gives dn_valid = up_valid and up_ready = dn_ready, and dn_addr always equals up_addr. With up_valid low, dn_valid is low.
- R4: Each cycle with up_valid and up_ready both high reduces the charged rule's counter by one, from the next cycle on. Within one refill window, no rule completes more than CREDITS handshakes.
- R5: While the charged rule's counter is zero, dn_valid and up_ready are both held low, whatever the values of up_valid and dn_ready. A cycle with dn_ready low uses no credit.
- R6: The refill occurs on every PERIOD-th rising edge after reset is released. It sets every counter to CREDITS. Unused credit does not carry over, so a saturated stream gets exactly CREDITS handshakes per window.
- R7: If a handshake on a rule completes on a refill edge, that rule's counter becomes CREDITS-1.
- R8: When several rules match, only the lowest-indexed matching rule is checked and charged. The other rules keep their credit.
- R9: Rules are independent. An exhausted rule does not stall addresses charged to another rule or matching no rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_addr | input | ADDR_W | Address from the master |
| up_valid | input | 1 | Address valid from the master |
| up_ready | output | 1 | Ready returned to the master (gated) |
| dn_addr | output | ADDR_W | Address toward the slave |
| dn_valid | output | 1 | Valid toward the slave (gated) |
| dn_ready | input | 1 | Ready from the slave |

## Verification
The gating of dn_valid and up_ready follows the inputs in the same cycle. The bench therefore drives each input on the falling edge and samples the outputs 1 ns later, before the next rising edge. A handshake changes a counter at the rising edge where it completes, so its effect shows in the sample of the following cycle. The bench's credit model spends credit at that same edge. The bench also counts rising edges since reset release to place each refill on every PERIOD-th edge. Using that count, it lines up one handshake exactly on a refill edge and counts the passes in complete windows.

// File: rtl/credit_gate.sv
module credit_gate #(
  parameter int ADDR_W    = 32,
  parameter int NUM_RULES = 2,
  parameter logic [NUM_RULES*ADDR_W-1:0] RULE_BASE = {32'h4000_0000, 32'h4000_1000},
  parameter logic [NUM_RULES*ADDR_W-1:0] RULE_MASK = {32'hFFFF_0000, 32'hFFFF_F000},
  parameter int CREDITS   = 4,
  parameter int PERIOD    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_valid,
  output logic              up_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_valid,
  input  logic              dn_ready
);
  localparam int CW    = $clog2(CREDITS + 1);
  localparam int PER_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int SEL_W = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1;
  localparam logic [CW-1:0] FULL = CW'(CREDITS);

  logic [NUM_RULES-1:0] hit, empty, charge;
  logic [SEL_W-1:0]     sel;
  logic                 any_hit, stall, fire, tick;
  logic [PER_W-1:0]     tmr;

  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int i = NUM_RULES - 1; i >= 0; i--)
      if (hit[i]) begin
        sel     = SEL_W'(i);
        any_hit = 1'b1;
      end
  end

  assign stall    = any_hit & empty[sel];
  assign dn_addr  = up_addr;
  assign dn_valid = up_valid & ~stall;
  assign up_ready = dn_ready & ~stall;
  assign fire     = up_valid & up_ready;
  assign tick     = (tmr == PER_W'(PERIOD - 1));

  always_ff @(posedge clk)
    if (!rst_n || tick) tmr <= '0;
    else                tmr <= tmr + 1'b1;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    logic [CW-1:0] cr;
    assign hit[g]    = ((up_addr ^ RULE_BASE[g*ADDR_W +: ADDR_W]) & RULE_MASK[g*ADDR_W +: ADDR_W]) == '0;
    assign empty[g]  = (cr == '0);
    assign charge[g] = fire & any_hit & (sel == SEL_W'(g));
    always_ff @(posedge clk)
      if (!rst_n)         cr <= FULL;
      else if (tick)      cr <= charge[g] ? FULL - 1'b1 : FULL;
      else if (charge[g]) cr <= cr - 1'b1;
  end
endmodule

// File: rtl/credit_gate_chk.sv
module credit_gate_chk #(
  parameter int NUM_RULES = 2,
  parameter int CREDITS   = 4,
  parameter int PERIOD    = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 up_valid,
  input logic                 up_ready,
  input logic                 dn_valid,
  input logic                 dn_ready,
  input logic                 tick,
  input logic [NUM_RULES-1:0] charge
);
  int unsigned cyc;
  always_ff @(posedge clk)
    if (!rst_n || cyc == PERIOD - 1) cyc <= 0;
    else                             cyc <= cyc + 1;

  // R3
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n) dn_valid |-> up_valid);
  // R3
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n) up_ready |-> dn_ready);
  // R5
  stall_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && dn_ready && !dn_valid) |-> !up_ready);
  // R6
  refill_period_chk: assert property (@(posedge clk) disable iff (!rst_n) tick == (cyc == PERIOD - 1));
  // R8
  one_charge_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(charge));

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_win
    int unsigned win;
    always_ff @(posedge clk)
      if (!rst_n)    win <= 0;
      else if (tick) win <= 32'(charge[g]);
      else           win <= win + 32'(charge[g]);
    // R4
    window_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) win <= CREDITS);
  end
endmodule

bind credit_gate credit_gate_chk #(.NUM_RULES(NUM_RULES), .CREDITS(CREDITS), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .tick(tick), .charge(charge)
);

// File: tb/credit_gate_tb.sv
module credit_gate_tb;
  localparam int PERIOD  = 32;
  localparam int CREDITS = 4;
  localparam logic [31:0] B0 = 32'h4000_1000, M0 = 32'hFFFF_F000;
  localparam logic [31:0] B1 = 32'h4000_0000, M1 = 32'hFFFF_0000;

  typedef struct packed {
    logic [31:0] addr;
    logic        vld;
    logic        rdy;
    logic [7:0]  n;
    logic [7:0]  tag;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h5000_0000, 1'b1, 1'b1, 8'd6, 8'd2}, // R2 unmatched passes
    '{32'h4000_1004, 1'b1, 1'b1, 8'd6, 8'd8}, // R8/R4/R5 overlap, rule0 charged
    '{32'h4000_2000, 1'b1, 1'b1, 8'd3, 8'd9}, // R9 rule1 unaffected
    '{32'h4000_1008, 1'b1, 1'b0, 8'd3, 8'd5}, // R5 stalled with dn_ready low
    '{32'h0000_0000, 1'b0, 1'b1, 8'd2, 8'd3}, // R3 idle
    '{32'h4000_1FFC, 1'b1, 1'b1, 8'd2, 8'd5}, // R5 rule0 still empty
    '{32'h5000_0010, 1'b1, 1'b1, 8'd2, 8'd9}, // R9 unmatched while rule0 empty
    '{32'h4000_2004, 1'b1, 1'b1, 8'd4, 8'd4}  // R4 rule1 spends its last credit
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] up_addr = '0, dn_addr;
  logic        up_valid = 1'b0, up_ready, dn_valid, dn_ready = 1'b0;

  int checks = 0, errors = 0, edges = 0, passes = 0;
  int cred [2];

  always #2 clk = ~clk;

  credit_gate #(.ADDR_W(32), .NUM_RULES(2), .RULE_BASE({B1, B0}), .RULE_MASK({M1, M0}),
                .CREDITS(CREDITS), .PERIOD(PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_addr(up_addr), .up_valid(up_valid), .up_ready(up_ready),
    .dn_addr(dn_addr), .dn_valid(dn_valid), .dn_ready(dn_ready));

  function automatic int rule_of(input logic [31:0] a);
    if (((a ^ B0) & M0) == 0) return 0;
    if (((a ^ B1) & M1) == 0) return 1;
    return -1;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    cred[0] = CREDITS; cred[1] = CREDITS; edges = 0;
  endtask

  task automatic step(input logic [31:0] a, input logic v, input logic r, input string req);
    int  idx;
    bit  allow, fire;
    up_addr = a; up_valid = v; dn_ready = r;
    #1;
    idx   = rule_of(a);
    allow = (idx < 0) || (cred[idx] > 0);
    check(req, "dn_valid", dn_valid, v && allow);
    check(req, "up_ready", up_ready, r && allow);
    check("R3", "dn_addr", dn_addr, a);
    fire = v && r && allow;
    if (fire) passes++;
    edges++;
    if (edges % PERIOD == 0) begin
      cred[0] = CREDITS; cred[1] = CREDITS;
    end
    if (fire && idx >= 0) cred[idx]--;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_until(input int phase);
    while (edges % PERIOD != phase) step(32'h0, 1'b0, 1'b1, "R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset the counters are full, so a rule address passes
    up_addr = 32'h4000_1000; up_valid = 1'b1; dn_ready = 1'b1; #1;
    check("R1", "dn_valid in reset", dn_valid, 1);
    check("R1", "up_ready in reset", up_ready, 1);
    @(negedge clk);
    rst_n = 1'b1; model_reset();

    // table walk
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < VECS[k].n; j++)
        step(VECS[k].addr, VECS[k].vld, VECS[k].rdy, $sformatf("R%0d", VECS[k].tag));

    // R1: mid-run reset restores full credit on the exhausted rules
    rst_n = 1'b0; @(posedge clk); @(negedge clk);
    rst_n = 1'b1; model_reset();
    passes = 0;
    for (int j = 0; j < CREDITS + 2; j++) step(32'h4000_1010, 1'b1, 1'b1, "R1");
    check("R1", "passes after reset", passes, CREDITS);

    // R6 / R4: saturated stream over whole windows, after idle windows (no carry-over)
    idle_until(0);
    repeat (2 * PERIOD) step(32'h0, 1'b0, 1'b1, "R6");
    for (int w = 0; w < 2; w++) begin
      passes = 0;
      repeat (PERIOD) step(32'h4000_3000, 1'b1, 1'b1, "R4");
      check("R6", "passes per window", passes, CREDITS);
    end

    // R7: handshake on the refill edge leaves CREDITS-1
    idle_until(PERIOD - 1);
    passes = 0;
    step(32'h4000_1020, 1'b1, 1'b1, "R7");
    check("R7", "pass on refill edge", passes, 1);
    passes = 0;
    for (int j = 0; j < CREDITS + 1; j++) step(32'h4000_1024, 1'b1, 1'b1, "R7");
    check("R7", "passes after refill-edge handshake", passes, CREDITS - 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule